// File: doc/BRIEF.md
# Dual-Controller Window Decoder with Reset Sequencer

This block sits between an 8-bit host memory bus and two peripheral controllers. It recognises a 512-byte window. The window's base comes from ten jumper inputs, with address bit 19 always required to be 1. The block drives one chip select per controller: the lower 256 bytes of the window belong to controller 1 and the upper 256 bytes to controller 2.

Two byte offsets in each half carry reset commands. These are offset 4h ("hold") and offset 5h ("free"). Writing 00h to either half's hold or free offset acts on both controllers. Writing 55h acts only on the controller that owns that half. Each controller has its own reset sequencer, a four-state machine, which keeps its reset output asserted for at least `MIN_CYCLES` clock cycles per pulse. A free command that arrives too early is held as pending and takes effect when the minimum time ends.

Sequencer states and transitions:
- `ST_RUN` (reset released): a hold command moves it to `ST_HOLD`.
- `ST_HOLD` (minimum time running, no release pending):
  - a free command moves it to `ST_HOLD_REL`, or straight to `ST_RUN` if the minimum ends in the same cycle;
  - the end of the minimum moves it to `ST_PARKED`.
- `ST_HOLD_REL` (minimum time running, release pending):
  - the end of the minimum moves it to `ST_RUN`;
  - a hold command cancels the pending release and moves it back to `ST_HOLD`, and the timer keeps running.
- `ST_PARKED` (minimum time done, still in reset): a free command moves it to `ST_RUN`.

A system reset puts both sequencers in `ST_HOLD_REL` with the timer at zero.

Top module: `dwr_top`

## Requirements
- R1: Any read or write strobe to window offsets 000h–0FFh raises `cs_ctl1`, and to offsets 100h–1FFh raises `cs_ctl2`. The chip selects are combinational from the bus inputs. With no strobe, neither select is raised.
- R2: An address hits the window only when bit 19 is 1, bits 18..15 equal `{~jumper_sel[3], jumper_sel[2:0]}`, and bits 14..9 equal `jumper_sel[9:4]`. Examples: jumper 0000000010 gives base D0000h, 0000000000 gives C0000h, and 0000111000 gives 80600h.
- R3: A write of 00h to offset 004h or 104h asserts both reset outputs. A write of 00h to offset 005h or 105h releases both.
- R4: A write of 55h to offset 004h (or 104h) asserts only `rst_ctl1` (or `rst_ctl2`). A write of 55h to offset 005h (or 105h) releases only that output.
- R5: A write of any value other than 00h or 55h to offsets 004h, 005h, 104h or 105h changes no reset output.
- R6: Writes to offsets 004h, 005h, 104h and 105h raise no chip select. Reads of those offsets do raise the chip select.
- R7: A reset output changes one clock after the command's write cycle. Once asserted, it stays high for at least `MIN_CYCLES` cycles. If no free command has arrived when the minimum ends, it stays high until one does.
- R8: A free command given before the minimum ends is remembered. The output falls exactly `MIN_CYCLES` cycles after the hold command.
- R9: A hold command given while a release is pending cancels that release without restarting the minimum timer.
- R10: While the system reset is active, both reset outputs are high. After the system reset is released they fall together after `MIN_CYCLES` clock edges.
- R11: Bus accesses outside the window raise no chip select and change no reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | 20 | Host memory address |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high, one cycle per write |
| jumper_sel | input | 10 | Base-address jumpers; [3:0] map to address bits 18..15, [9:4] map to bits 14..9 |
| cs_ctl1 | output | 1 | Chip select for controller 1 |
| cs_ctl2 | output | 1 | Chip select for controller 2 |
| rst_ctl1 | output | 1 | Reset to controller 1, active high |
| rst_ctl2 | output | 1 | Reset to controller 2, active high |

## Verification
A sequencer in the wrong state shows up on its reset output within one clock of the next command. It also shows up at the cycle where the minimum timer ends, which is when a pending release must fall and a parked pulse must stay high. The bench therefore checks the reset outputs on every cycle of each hold window, not only at its end. That catches an off-by-one in the timer, a lost pending release, and a cancel that fails to clear it. Decode faults show up immediately as a wrong chip select on the same cycle as the strobe.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_HOLD,
        ST_HOLD_REL,
        ST_PARKED
    } rst_state_e;

    localparam logic [7:0] OFS_HOLD  = 8'h04;
    localparam logic [7:0] OFS_FREE  = 8'h05;
    localparam logic [7:0] CODE_BOTH = 8'h00;
    localparam logic [7:0] CODE_ONE  = 8'h55;
    localparam int         N_CHAN    = 2;

endpackage

// File: rtl/dwr_window_decode.sv
module dwr_window_decode
    import dwr_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int HALF_AW = 8,
    localparam int WIN_AW = HALF_AW + 1,
    localparam int JMP_W  = ADDR_W - 1 - WIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              rd,
    input  logic              wr,
    input  logic [JMP_W-1:0]  jumper,
    output logic [N_CHAN-1:0] cs,
    output logic [N_CHAN-1:0] hold_req,
    output logic [N_CHAN-1:0] free_req
);

    logic [JMP_W-1:0]   tag_exp;
    logic               hit;
    logic               half;
    logic               ofs_hold;
    logic               ofs_free;
    logic               ctl_ofs;
    logic               code_both;
    logic               code_one;

    always_comb begin
        tag_exp   = {~jumper[3], jumper[2:0], jumper[JMP_W-1:4]};
        hit       = addr[ADDR_W-1] && (addr[ADDR_W-2:WIN_AW] == tag_exp);
        half      = addr[HALF_AW];
        ofs_hold  = (addr[HALF_AW-1:0] == HALF_AW'(OFS_HOLD));
        ofs_free  = (addr[HALF_AW-1:0] == HALF_AW'(OFS_FREE));
        ctl_ofs   = ofs_hold || ofs_free;
        code_both = (wdata == CODE_BOTH);
        code_one  = (wdata == CODE_ONE);
    end

    for (genvar k = 0; k < N_CHAN; k++) begin : g_chan
        logic mine;
        logic targeted;
        always_comb begin
            mine        = hit && (half == 1'(k));
            targeted    = wr && hit && (code_both || (code_one && half == 1'(k)));
            cs[k]       = mine && (rd || (wr && !ctl_ofs));
            hold_req[k] = targeted && ofs_hold;
            free_req[k] = targeted && ofs_free;
        end
    end

    // R2: no select without address bit 19
    a_r2_cs_needs_a19: assert property (@(posedge clk) disable iff (!rst_n)
        (|cs) |-> addr[ADDR_W-1]);

    // R1: each select only for its own half
    a_r1_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        cs[0] |-> !addr[HALF_AW]);
    a_r1_high_half: assert property (@(posedge clk) disable iff (!rst_n)
        cs[1] |-> addr[HALF_AW]);

    // R6: control-offset writes are not forwarded
    a_r6_ctl_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && (addr[HALF_AW-1:0] == HALF_AW'(4) || addr[HALF_AW-1:0] == HALF_AW'(5)))
        |-> (cs == '0));

    // R5: unrecognised data codes issue no command
    a_r5_other_codes_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata != 8'h00 && wdata != 8'h55) |-> (hold_req == '0 && free_req == '0));

endmodule

// File: rtl/dwr_rst_seq.sv
module dwr_rst_seq
    import dwr_pkg::*;
#(
    parameter int MIN_CYCLES = 125000,
    localparam int CNT_W     = $clog2(MIN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic free_req,
    output logic rst_out
);

    rst_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic min_done;
    logic timing;

    always_comb begin
        min_done = (cnt_q == CNT_W'(MIN_CYCLES - 1));
        timing   = (state_q == ST_HOLD) || (state_q == ST_HOLD_REL);
        cnt_d    = timing ? CNT_W'(cnt_q + 1'b1) : '0;
        state_d  = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (hold_req) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (free_req)      state_d = min_done ? ST_RUN : ST_HOLD_REL;
                else if (min_done) state_d = ST_PARKED;
            end
            ST_HOLD_REL: begin
                if (hold_req)      state_d = min_done ? ST_PARKED : ST_HOLD;
                else if (min_done) state_d = ST_RUN;
            end
            ST_PARKED: begin
                if (free_req) state_d = ST_RUN;
            end
            default: state_d = ST_HOLD_REL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD_REL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        rst_out = (state_q != ST_RUN);
    end

    // checker: consecutive cycles the output has been high, saturating
    logic [CNT_W-1:0] held_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  held_q <= '0;
        else if (!rst_out)                           held_q <= '0;
        else if (held_q != CNT_W'(MIN_CYCLES))       held_q <= held_q + 1'b1;
    end

    // R7: every pulse lasts at least MIN_CYCLES
    a_r7_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (held_q >= CNT_W'(MIN_CYCLES)));

    // R3: a hold command always leaves the output asserted
    a_r3_hold_takes: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> rst_out);

    // R4: the output only rises in response to a hold command
    a_r4_rise_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(hold_req));

    // R7: a parked output drops on the next free command
    a_r7_parked_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARKED && free_req) |=> !rst_out);

endmodule

// File: rtl/dwr_top.sv
module dwr_top
    import dwr_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int HALF_AW    = 8,
    parameter int MIN_CYCLES = 125000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [7:0]                  bus_wdata,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [ADDR_W-HALF_AW-3:0]   jumper_sel,
    output logic                        cs_ctl1,
    output logic                        cs_ctl2,
    output logic                        rst_ctl1,
    output logic                        rst_ctl2
);

    logic [N_CHAN-1:0] cs;
    logic [N_CHAN-1:0] hold_req;
    logic [N_CHAN-1:0] free_req;
    logic [N_CHAN-1:0] rst_vec;

    dwr_window_decode #(
        .ADDR_W  (ADDR_W),
        .HALF_AW (HALF_AW)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .jumper   (jumper_sel),
        .cs       (cs),
        .hold_req (hold_req),
        .free_req (free_req)
    );

    for (genvar k = 0; k < N_CHAN; k++) begin : g_seq
        dwr_rst_seq #(
            .MIN_CYCLES (MIN_CYCLES)
        ) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_req (hold_req[k]),
            .free_req (free_req[k]),
            .rst_out  (rst_vec[k])
        );
    end

    always_comb begin
        cs_ctl1  = cs[0];
        cs_ctl2  = cs[1];
        rst_ctl1 = rst_vec[0];
        rst_ctl2 = rst_vec[1];
    end

endmodule

// File: tb/tb_dwr_top.sv
module tb_dwr_top;

    localparam int MIN = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  jumper_sel = 10'b000000_0010;
    logic        cs_ctl1, cs_ctl2, rst_ctl1, rst_ctl2;

    always #4 clk = ~clk;

    dwr_top #(.MIN_CYCLES(MIN)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .jumper_sel(jumper_sel),
        .cs_ctl1(cs_ctl1), .cs_ctl2(cs_ctl2), .rst_ctl1(rst_ctl1), .rst_ctl2(rst_ctl2)
    );

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t queue_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // monitor: pops one expectation per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (queue_q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = queue_q.pop_front();
                act = {cs_ctl1, cs_ctl2, rst_ctl1, rst_ctl2};
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: {cs1,cs2,rst1,rst2} actual %b expected %b",
                             it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(input logic [19:0] a, input logic [7:0] d, input logic rd,
                        input logic wr, input logic [3:0] exp, input string tag);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_rd    = rd;
        bus_wr    = wr;
        queue_q.push_back('{exp, tag});
    endtask

    task automatic idle(input int n, input logic [3:0] exp, input string tag);
        for (int i = 0; i < n; i++) step(20'h00000, 8'h00, 1'b0, 1'b0, exp, tag);
    endtask

    task automatic wr_b(input logic [19:0] a, input logic [7:0] d, input logic [3:0] exp,
                        input string tag);
        step(a, d, 1'b0, 1'b1, exp, tag);
    endtask

    task automatic rd_b(input logic [19:0] a, input logic [3:0] exp, input string tag);
        step(a, 8'h00, 1'b1, 1'b0, exp, tag);
    endtask

    initial begin
        // R10: both resets high during system reset, then release after MIN edges
        idle(2, 4'b0011, "R10 during system reset");
        @(negedge clk);
        rst_n = 1'b1;
        queue_q.push_back('{4'b0011, "R10 first edge after release"});
        idle(MIN - 2, 4'b0011, "R10 still held");
        idle(1, 4'b0000, "R10 released after minimum");

        // R1: half routing, reads and writes, no strobe
        rd_b(20'hD0010, 4'b1000, "R1 read low half");
        rd_b(20'hD0123, 4'b0100, "R1 read high half");
        wr_b(20'hD01FF, 8'h12, 4'b0100, "R1 write high half top byte");
        wr_b(20'hD0007, 8'h00, 4'b1000, "R1 write low half");
        step(20'hD0010, 8'h00, 1'b0, 1'b0, 4'b0000, "R1 no strobe");

        // R11: outside the window
        rd_b(20'hD0200, 4'b0000, "R11 read just past window");
        rd_b(20'h50010, 4'b0000, "R11 read with A19 low");
        wr_b(20'hD0204, 8'h00, 4'b0000, "R11 hold code outside window");
        idle(1, 4'b0000, "R11 no reset after outside write");

        // R6 / R5: control offsets
        rd_b(20'hD0004, 4'b1000, "R6 read of hold offset selects");
        rd_b(20'hD0105, 4'b0100, "R6 read of high free offset selects");
        wr_b(20'hD0004, 8'h33, 4'b0000, "R6 R5 write 33h to hold offset");
        wr_b(20'hD0104, 8'hAA, 4'b0000, "R5 write AAh to high hold offset");
        wr_b(20'hD0004, 8'h01, 4'b0000, "R5 write 01h to hold offset");
        idle(1, 4'b0000, "R5 resets unchanged");

        // R4 + R7: individual hold on channel 1, parked until free
        wr_b(20'hD0004, 8'h55, 4'b0010, "R4 hold ctl1 only");
        idle(MIN, 4'b0010, "R7 ctl1 parked without free");
        idle(2, 4'b0010, "R7 ctl1 stays parked");
        wr_b(20'hD0005, 8'h55, 4'b0000, "R4 free ctl1 only");
        wr_b(20'hD0005, 8'h55, 4'b0000, "R4 free on running ctl1 no effect");

        // R8: early free on channel 2
        wr_b(20'hD0104, 8'h55, 4'b0001, "R4 hold ctl2 only");
        wr_b(20'hD0105, 8'h55, 4'b0001, "R8 early free ctl2 still held");
        idle(MIN - 2, 4'b0001, "R8 ctl2 held to minimum");
        idle(1, 4'b0000, "R8 ctl2 released at minimum");

        // R3: global hold via high half, global free via low half
        wr_b(20'hD0104, 8'h00, 4'b0011, "R3 global hold via 104h");
        idle(MIN, 4'b0011, "R3 both parked");
        wr_b(20'hD0005, 8'h00, 4'b0000, "R3 global free via 005h");

        // R3 + R8: global hold via low half, early global free via high half
        wr_b(20'hD0004, 8'h00, 4'b0011, "R3 global hold via 004h");
        wr_b(20'hD0105, 8'h00, 4'b0011, "R8 early global free");
        idle(MIN - 2, 4'b0011, "R8 both held to minimum");
        idle(1, 4'b0000, "R8 both released at minimum");

        // R9: pending free cancelled by a new hold, timer not restarted
        wr_b(20'hD0004, 8'h55, 4'b0010, "R9 hold ctl1");
        wr_b(20'hD0005, 8'h55, 4'b0010, "R9 early free ctl1");
        wr_b(20'hD0004, 8'h55, 4'b0010, "R9 hold cancels pending free");
        idle(MIN, 4'b0010, "R9 ctl1 parked after cancel");
        wr_b(20'hD0005, 8'h55, 4'b0000, "R9 free after cancel");

        // mixed: global hold, individual free, then global free
        wr_b(20'hD0004, 8'h00, 4'b0011, "R3 global hold again");
        idle(MIN, 4'b0011, "R7 both parked again");
        wr_b(20'hD0105, 8'h55, 4'b0010, "R4 free ctl2 out of global hold");
        wr_b(20'hD0105, 8'h00, 4'b0000, "R3 global free releases ctl1");

        // R2: other jumper settings
        @(negedge clk);
        jumper_sel = 10'b000000_0000;
        rd_b(20'hC0010, 4'b1000, "R2 base C0000h low half");
        rd_b(20'hD0010, 4'b0000, "R2 old base no longer hits");
        @(negedge clk);
        jumper_sel = 10'b000011_1000;
        rd_b(20'h80600, 4'b1000, "R2 base 80600h low half");
        rd_b(20'h80700, 4'b0100, "R2 base 80600h high half");
        rd_b(20'h80000, 4'b0000, "R2 bits 14..9 mismatch");
        idle(1, 4'b0000, "R2 idle");

        while (queue_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule